// File: doc/BRIEF.md
# Receive Byte Buffer with Latency Flush

This block buffers bytes coming from a serial receiver until a packet-oriented host reader should collect them. It keeps them in a first-in first-out store of 384 bytes and raises a flush request when a transfer to the host is worthwhile. Three conditions count as worthwhile:
- The buffer holds a packet's worth of data (62 bytes).
- A configured trigger byte has arrived.
- A programmable latency timer has expired while data is waiting.

The latency timer counts pulses from a 1 ms tick input, so a short message is never held back for long.

The write side is a valid/ready stream. `in_ready` is low while the buffer is full. The serial receiver cannot be stalled, so a byte offered while `in_ready` is low is discarded and a sticky overflow flag is set. The read side is also valid/ready. A byte transfers on any clock edge where `out_valid` and `out_ready` are both high, and `out_data` shows the oldest byte whenever `out_valid` is high. The configuration inputs and the flush request are plain level signals.

Top module: `rx_latency_buffer`

## Requirements
- R1: Bytes leave in the order they were accepted. `out_valid` is high exactly when at least one byte is held, and a byte is removed on each edge where `out_valid` and `out_ready` are both high.
- R2: `in_ready` is low when 384 bytes are held. A byte offered while full is discarded, and the stored contents stay unchanged.
- R3: `ovf_flag` goes high on the edge that discards a byte. It stays high until reset.
- R4: `flush_req` is high whenever 62 or more bytes are held, independent of timer and trigger.
- R5: The latency timer advances only on clock edges where `tick_1ms` is high and the buffer is non-empty. When it reaches `cfg_timeout_ms` ticks, `flush_req` goes high from the next cycle.
- R6: A `cfg_timeout_ms` of 0 behaves as 1, so the first tick with data held expires the timer.
- R7: The timer restarts from zero whenever the buffer becomes empty. Ticks that arrive while the buffer is empty are not counted.
- R8: When `cfg_evt_en` is 1, accepting a byte equal to `cfg_evt_byte` raises `flush_req` from the next cycle. When `cfg_evt_en` is 0, that byte has no effect on `flush_req`.
- R9: A flush request raised by the timer or by the trigger byte stays high until the buffer is empty. `flush_req` is never high while the buffer is empty.
- R10: After reset, `out_valid`, `flush_req` and `ovf_flag` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered by the receiver |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Buffer has room |
| out_valid | output | 1 | Oldest byte available |
| out_data | output | 8 | Oldest byte |
| out_ready | input | 1 | Reader takes the byte |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| cfg_timeout_ms | input | 8 | Latency timeout in ms (0 acts as 1) |
| cfg_evt_en | input | 1 | Enable trigger-byte flush |
| cfg_evt_byte | input | 8 | Trigger byte value |
| flush_req | output | 1 | Host transfer should start |
| ovf_flag | output | 1 | Sticky flag: a byte was discarded |

## Verification
The bench fills the buffer completely, then offers one more byte and drains it. This shows whether a design that overwrote or counted the rejected byte would corrupt the order or return 385 bytes. It counts ticks against the timeout one at a time, so an off-by-one expiry is caught. It also checks that a zero timeout still expires and that ticks arriving while the buffer is empty are ignored. It empties the buffer part-way through a timeout to catch a timer that fails to restart and fires early. It steps across the 62-byte threshold in both directions. It sends the trigger byte with the enable on and with it off.

// File: rtl/rxlb_pkg.sv
package rxlb_pkg;
  typedef logic [7:0] byte_t;

  function automatic logic [7:0] eff_timeout(input logic [7:0] cfg);
    eff_timeout = (cfg == 8'd0) ? 8'd1 : cfg;
  endfunction
endpackage

// File: rtl/rxlb_store.sv
module rxlb_store #(
  parameter int DEPTH = 384,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  rxlb_pkg::byte_t wr_data,
  input  logic            rd_en,
  output rxlb_pkg::byte_t rd_data,
  output logic [CW-1:0]   level,
  output logic            full,
  output logic            empty
);
  rxlb_pkg::byte_t mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign rd_data = mem[rp];

  logic do_wr, do_rd;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2: a full buffer with no read stays full (rejected write adds nothing)
  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
  // R1: occupancy never exceeds capacity
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
endmodule

// File: rtl/rxlb_timer.sv
module rxlb_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic [7:0] cfg_ms,
  output logic       expire
);
  logic [7:0] cnt;
  logic [7:0] lim;
  logic [8:0] nxt;

  assign lim    = rxlb_pkg::eff_timeout(cfg_ms);
  assign nxt    = {1'b0, cnt} + 9'd1;
  assign expire = tick && active && (nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!active)    cnt <= '0;
    else if (expire)     cnt <= '0;
    else if (tick)       cnt <= nxt[7:0];
  end

  // R7: an empty buffer leaves the timer at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == 8'd0));
  // R5: without a tick the count does not move
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(cnt) || !$past(active));
endmodule

// File: rtl/rx_latency_buffer.sv
module rx_latency_buffer #(
  parameter int DEPTH  = 384,
  parameter int THRESH = 62,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  input  logic       tick_1ms,
  input  logic [7:0] cfg_timeout_ms,
  input  logic       cfg_evt_en,
  input  logic [7:0] cfg_evt_byte,
  output logic       flush_req,
  output logic       ovf_flag
);
  logic [CW-1:0] level;
  logic full, empty, expire, pending, evt_hit;

  rxlb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid), .wr_data(in_data),
    .rd_en(out_ready), .rd_data(out_data),
    .level(level), .full(full), .empty(empty)
  );

  rxlb_timer u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .active(!empty),
    .cfg_ms(cfg_timeout_ms), .expire(expire)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign evt_hit   = cfg_evt_en && in_valid && !full && (in_data == cfg_evt_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (expire || evt_hit) pending <= 1'b1;
      else if (empty)        pending <= 1'b0;
      if (in_valid && full)  ovf_flag <= 1'b1;
    end
  end

  assign flush_req = (level >= CW'(THRESH)) || (pending && !empty);

  // R3: overflow flag never clears outside reset
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R9: no flush request with nothing to send
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !flush_req);
  // R4: threshold occupancy always requests a flush
  a_r4_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= CW'(THRESH)) |-> flush_req);
endmodule

// File: tb/test_rx_latency_buffer.sv
module test_rx_latency_buffer;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, tick_1ms = 0, cfg_evt_en = 0;
  logic [7:0] in_data = 0, cfg_timeout_ms = 8'd200, cfg_evt_byte = 8'h0D;
  logic in_ready, out_valid, flush_req, ovf_flag;
  logic [7:0] out_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_latency_buffer i_rx_latency_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .tick_1ms(tick_1ms), .cfg_timeout_ms(cfg_timeout_ms),
    .cfg_evt_en(cfg_evt_en), .cfg_evt_byte(cfg_evt_byte),
    .flush_req(flush_req), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0; in_valid = 0; out_ready = 0; tick_1ms = 0;
    @(negedge clk) rst_n = 1;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk) in_valid = 1; in_data = b;
    @(negedge clk) in_valid = 0;
  endtask

  task automatic pop(output logic [7:0] b, output logic v);
    @(negedge clk) out_ready = 1; b = out_data; v = out_valid;
    @(negedge clk) out_ready = 0;
  endtask

  task automatic tick();
    @(negedge clk) tick_1ms = 1;
    @(negedge clk) tick_1ms = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 out_valid", out_valid, 0);
    chk("R10 flush_req", flush_req, 0);
    chk("R10 ovf_flag", ovf_flag, 0);
    chk("R10 in_ready", in_ready, 1);
  endtask

  task automatic t_full();
    logic [7:0] b; logic v;
    do_reset();
    for (int i = 0; i < 384; i++) push(8'(i * 7 + 3));
    chk("R2 in_ready full", in_ready, 0);
    chk("R3 no ovf yet", ovf_flag, 0);
    push(8'hEE);
    chk("R3 ovf set", ovf_flag, 1);
    for (int i = 0; i < 384; i++) begin
      pop(b, v);
      if (i == 0 || i == 383 || b != 8'(i * 7 + 3)) chk("R1 order", b, 8'(i * 7 + 3));
    end
    chk("R2 dropped byte absent", out_valid, 0);
    chk("R3 ovf sticky", ovf_flag, 1);
  endtask

  task automatic t_thresh();
    logic [7:0] b; logic v;
    do_reset();
    cfg_timeout_ms = 8'd200; cfg_evt_en = 0;
    for (int i = 0; i < 61; i++) push(8'(i));
    chk("R4 below threshold", flush_req, 0);
    push(8'd61);
    chk("R4 at threshold", flush_req, 1);
    pop(b, v);
    chk("R1 first byte", b, 0);
    chk("R4 back below", flush_req, 0);
  endtask

  task automatic t_timer();
    logic [7:0] b; logic v;
    do_reset();
    cfg_timeout_ms = 8'd3; cfg_evt_en = 0;
    repeat (5) tick();
    push(8'h41);
    tick(); tick();
    chk("R7 empty ticks ignored", flush_req, 0);
    pop(b, v);
    push(8'h42);
    tick(); tick();
    chk("R7 restart after empty", flush_req, 0);
    tick();
    chk("R5 expire at 3", flush_req, 1);
    push(8'h43);
    chk("R9 held", flush_req, 1);
    pop(b, v);
    chk("R1 data", b, 8'h42);
    chk("R9 held nonempty", flush_req, 1);
    pop(b, v);
    chk("R9 cleared empty", flush_req, 0);
    push(8'h44);
    chk("R9 pending gone", flush_req, 0);
  endtask

  task automatic t_zero();
    do_reset();
    cfg_timeout_ms = 8'd0;
    push(8'h10);
    chk("R6 no tick yet", flush_req, 0);
    tick();
    chk("R6 zero acts as one", flush_req, 1);
    cfg_timeout_ms = 8'd200;
  endtask

  task automatic t_event();
    do_reset();
    cfg_timeout_ms = 8'd200; cfg_evt_byte = 8'h0D; cfg_evt_en = 0;
    push(8'h0D);
    chk("R8 disabled", flush_req, 0);
    cfg_evt_en = 1;
    push(8'h0C);
    chk("R8 other byte", flush_req, 0);
    push(8'h0D);
    chk("R8 trigger", flush_req, 1);
    cfg_evt_en = 0;
  endtask

  initial begin
    t_reset();
    t_thresh();
    t_timer();
    t_zero();
    t_event();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule